// File: doc/BRIEF.md
# Bus Address-Sequence Command Detector

This block sits beside an SRAM-style memory port and watches its read traffic for a secret six-step address pattern. When software reads the right six locations in the right order, the block asks a nonvolatile controller either to copy the SRAM contents into nonvolatile cells or to copy them back. Requests can also come from three plain control pins: a hardware save pin, a power-loss indication and a power-on indication. A save is skipped when nothing was written since the last nonvolatile operation.

The request to the controller is a one-entry command stream. `op_valid` rises with `op_kind` and both hold until the controller takes the command with `op_ready`. The block does not withdraw or change a pending command. `busy` covers the whole operation. While `busy` is high, the SRAM enables are forced low, the matcher freezes, and any new request is dropped. All inputs are sampled on the rising edge of `clk`.

Top module: `nvseq_cmd_detect`

## Requirements
- R1: After reset, `busy`, `op_valid` and `dirty` are 0.
- R2: Six reads whose low 16 address bits are 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0 request a save (`op_kind`=0). The same five reads followed by 0x4C63 request a restore (`op_kind`=1). `op_valid` is high in the cycle after the sixth read is sampled.
- R3: Address bit 16 is never compared, so the sequence matches with either value of it.
- R4: A read access is `ce_n`=0, `we_n`=1, `oe_n`=0, and a write access is `ce_n`=0, `we_n`=0. A write access resets the matcher to its first step. So does a read whose address is not the expected one. Cycles with `ce_n`=1, or with both `we_n` and `oe_n` high, leave the matcher unchanged.
- R5: Once `op_valid` is high, it stays high and `op_kind` stays stable until a cycle with `op_ready`=1.
- R6: `busy` is high from the cycle after a request is accepted until BUSY_CYCLES cycles after the command handshake. While `busy` is high: `sram_rd_en` and `sram_wr_en` stay 0, the matcher ignores bus accesses, and all requests are dropped.
- R7: `dirty` becomes 1 after a write access that passes, and goes to 0 when an operation starts.
- R8: A save request while `dirty`=0, with no write in the same cycle, produces neither `op_valid` nor `busy`.
- R9: `pwr_down_req` and `hw_store_req` request a save, and `pwr_up_req` requests a restore. When several sources request in the same cycle, the priority is power-down, then hardware pin, then power-up, then the bus sequence. Only the winner is considered.
- R10: A write access sampled in the same cycle as a save request counts as new data, so the save is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| hw_store_req | input | 1 | Hardware save request pulse |
| pwr_down_req | input | 1 | Power-loss save request pulse |
| pwr_up_req | input | 1 | Power-on restore request pulse |
| sram_rd_en | output | 1 | Read access passed to the SRAM |
| sram_wr_en | output | 1 | Write access passed to the SRAM |
| busy | output | 1 | Nonvolatile operation in progress |
| op_valid | output | 1 | Command to the nonvolatile controller is valid |
| op_ready | input | 1 | Controller accepts the command |
| op_kind | output | 1 | 0 = save, 1 = restore |
| dirty | output | 1 | SRAM written since the last nonvolatile operation |

## Verification
A write access and a save request can land in the same sampling cycle. In that case the write must be treated as new data, even though the dirty flag is still 0 at that edge. The directed case applies a write together with the hardware save pin while the flag is clear. It expects `op_valid` in the next cycle and `dirty` back at 0. Random traffic also fires the control pins over write cycles, and a cycle-level bench model judges every edge.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic {
    OP_STORE  = 1'b0,
    OP_RECALL = 1'b1
  } nv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RUN  = 2'd2
  } op_state_e;

  localparam int SEQ_LEN    = 6;
  localparam int PREFIX_LEN = SEQ_LEN - 1;
  localparam logic [15:0] KEY_STORE  = 16'h8FC0;
  localparam logic [15:0] KEY_RECALL = 16'h4C63;

  // common prefix of the unlock pattern, step by step
  function automatic logic [15:0] prefix_addr(input int step);
    case (step)
      0:       prefix_addr = 16'h4E38;
      1:       prefix_addr = 16'hB1C7;
      2:       prefix_addr = 16'h83E0;
      3:       prefix_addr = 16'h7C1F;
      default: prefix_addr = 16'h703F;
    endcase
  endfunction

endpackage

// File: rtl/nvseq_matcher.sv
module nvseq_matcher
  import nvseq_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             rd_acc,
  input  logic             wr_acc,
  input  logic [CMP_W-1:0] addr_lo,
  output logic             fire,
  output nv_op_e           fire_kind
);

  localparam int IDX_W = $clog2(SEQ_LEN);

  logic [IDX_W-1:0]      idx;
  logic [PREFIX_LEN-1:0] step_hit;
  logic                  on_last, key_st, key_rc, prefix_ok;

  // one comparator per prefix step
  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
    assign step_hit[g] = (addr_lo == prefix_addr(g));
  end

  assign on_last   = (idx == IDX_W'(PREFIX_LEN));
  assign key_st    = (addr_lo == KEY_STORE);
  assign key_rc    = (addr_lo == KEY_RECALL);
  assign prefix_ok = !on_last && step_hit[idx];

  assign fire      = !hold && rd_acc && on_last && (key_st || key_rc);
  assign fire_kind = key_rc ? OP_RECALL : OP_STORE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (!hold) begin
      if (wr_acc) begin
        idx <= '0;
      end else if (rd_acc) begin
        if (prefix_ok) idx <= idx + 1'b1;
        else           idx <= '0;
      end
    end
  end

  a_r4_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !hold) |=> (idx == '0));

  a_r6_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(idx));

  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(PREFIX_LEN));

endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pass,
  input  logic clear,
  output logic dirty,
  output logic dirty_eff
);

  // a write in the same cycle as an operation start counts as new data
  assign dirty_eff = dirty || wr_pass;

  always_ff @(posedge clk) begin
    if (!rst_n)      dirty <= 1'b0;
    else if (clear)  dirty <= 1'b0;
    else if (wr_pass) dirty <= 1'b1;
  end

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !dirty);

  a_r7_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pass && !clear) |=> dirty);

endmodule

// File: rtl/nvseq_opctl.sv
module nvseq_opctl
  import nvseq_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  nv_op_e start_kind,
  input  logic   op_ready,
  output logic   busy,
  output logic   op_valid,
  output nv_op_e op_kind
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

  op_state_e        state;
  logic [CNT_W-1:0] cnt;

  assign busy     = (state != ST_IDLE);
  assign op_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_kind <= OP_STORE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_REQ;
          op_kind <= start_kind;
        end
        ST_REQ: if (op_ready) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          if (cnt == CNT_LAST) state <= ST_IDLE;
          else                 cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r5_hold_command: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind)));

  a_r6_busy_starts_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> op_valid);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);

endmodule

// File: rtl/nvseq_cmd_detect.sv
module nvseq_cmd_detect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int CMP_W       = 16,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hw_store_req,
  input  logic              pwr_down_req,
  input  logic              pwr_up_req,
  output logic              sram_rd_en,
  output logic              sram_wr_en,
  output logic              busy,
  output logic              op_valid,
  input  logic              op_ready,
  output logic              op_kind,
  output logic              dirty
);

  logic   rd_acc, wr_acc;
  logic   sw_fire;
  nv_op_e sw_kind;
  logic   req_any;
  nv_op_e req_kind;
  logic   dirty_eff, start;
  nv_op_e kind_q;
  logic   unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:CMP_W];

  assign rd_acc = !ce_n && we_n && !oe_n;
  assign wr_acc = !ce_n && !we_n;

  // access gating: the SRAM sees nothing during a nonvolatile operation
  assign sram_rd_en = rd_acc && !busy;
  assign sram_wr_en = wr_acc && !busy;

  nvseq_matcher #(.CMP_W(CMP_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (busy),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .addr_lo   (addr[CMP_W-1:0]),
    .fire      (sw_fire),
    .fire_kind (sw_kind)
  );

  // fixed priority: power loss, hardware pin, power on, bus sequence
  always_comb begin
    req_any  = 1'b1;
    req_kind = OP_STORE;
    if (pwr_down_req)      req_kind = OP_STORE;
    else if (hw_store_req) req_kind = OP_STORE;
    else if (pwr_up_req)   req_kind = OP_RECALL;
    else if (sw_fire)      req_kind = sw_kind;
    else                   req_any  = 1'b0;
  end

  assign start = req_any && !busy && ((req_kind == OP_RECALL) || dirty_eff);

  nvseq_dirty u_dirty (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pass   (sram_wr_en),
    .clear     (start),
    .dirty     (dirty),
    .dirty_eff (dirty_eff)
  );

  nvseq_opctl #(.BUSY_CYCLES(BUSY_CYCLES)) u_op (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (req_kind),
    .op_ready   (op_ready),
    .busy       (busy),
    .op_valid   (op_valid),
    .op_kind    (kind_q)
  );

  assign op_kind = kind_q;

  a_r8_store_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && (kind_q == OP_STORE)) |-> $past(dirty_eff));

  a_r6_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> !sram_wr_en && !sram_rd_en);

  a_r9_powerdown_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_req && !busy && dirty_eff) |=> (op_valid && kind_q == OP_STORE));

endmodule

// File: tb/nvseq_cmd_detect_bench.sv
`timescale 1ns/1ps
module nvseq_cmd_detect_bench;
  localparam int NB = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce_n, we_n, oe_n, hw, pd, pu, rdy;
  logic [16:0] addr;
  logic rd_en, wr_en, busy, op_valid, op_kind, dirty;

  nvseq_cmd_detect #(.BUSY_CYCLES(NB)) u_nvseq_cmd_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .hw_store_req(hw), .pwr_down_req(pd), .pwr_up_req(pu),
    .sram_rd_en(rd_en), .sram_wr_en(wr_en), .busy(busy),
    .op_valid(op_valid), .op_ready(rdy), .op_kind(op_kind), .dirty(dirty)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model state
  int m_state = 0, m_cnt = 0, m_idx = 0, m_kind = 0;
  bit m_dirty = 0;

  function automatic logic [15:0] seqa(input int i);
    case (i)
      0: return 16'h4E38;
      1: return 16'hB1C7;
      2: return 16'h83E0;
      3: return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, w, o, input logic [16:0] a,
                      input logic h, p_d, p_u, r);
    bit mb, erd, ewr, sf, rq, deff;
    int sk, rk;
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a; hw = h; pd = p_d; pu = p_u; rdy = r;
    #1;
    mb  = (m_state != 0);
    erd = !c && w && !o && !mb;
    ewr = !c && !w && !mb;
    check(mb ? "R6" : tag, "sram_rd_en", rd_en, erd);
    check(mb ? "R6" : tag, "sram_wr_en", wr_en, ewr);
    @(posedge clk);
    if (!mb) begin
      sf = 0; sk = 0;
      if (erd) begin
        if (m_idx < 5) m_idx = (a[15:0] == seqa(m_idx)) ? m_idx + 1 : 0;
        else begin
          if (a[15:0] == 16'h8FC0) begin sf = 1; sk = 0; end
          if (a[15:0] == 16'h4C63) begin sf = 1; sk = 1; end
          m_idx = 0;
        end
      end else if (ewr) m_idx = 0;
      deff = m_dirty || ewr;
      rq = 1; rk = 0;
      if (p_d) rk = 0; else if (h) rk = 0; else if (p_u) rk = 1;
      else if (sf) rk = sk; else rq = 0;
      if (rq && (rk == 1 || deff)) begin
        m_state = 1; m_kind = rk; m_dirty = 0;
      end else m_dirty = deff;
    end else if (m_state == 1) begin
      if (r) begin m_state = 2; m_cnt = 0; end
    end else begin
      if (m_cnt == NB - 1) m_state = 0; else m_cnt++;
    end
    #1;
    check(tag, "busy", busy, m_state != 0);
    check(tag, "op_valid", op_valid, m_state == 1);
    if (m_state == 1) check(tag, "op_kind", op_kind, m_kind);
    check(tag, "dirty", dirty, m_dirty);
  endtask

  task automatic rd(input logic [16:0] a, input logic r = 1'b1);
    step(1'b0, 1'b1, 1'b0, a, 1'b0, 1'b0, 1'b0, r);
  endtask
  task automatic wr(input logic [16:0] a);
    step(1'b0, 1'b0, 1'b1, a, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask
  task automatic idle(input logic r = 1'b1);
    step(1'b1, 1'b1, 1'b1, 17'h0, 1'b0, 1'b0, 1'b0, r);
  endtask
  task automatic seq(input logic [15:0] last, input logic hi);
    for (int i = 0; i < 5; i++) rd({hi, seqa(i)});
    rd({hi, last});
  endtask
  task automatic drain();
    int guard = 0;
    while (m_state != 0 && guard < 100) begin idle(); guard++; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; addr = '0; hw = 0; pd = 0; pu = 0; rdy = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "busy", busy, 0);
    check("R1", "op_valid", op_valid, 0);
    check("R1", "dirty", dirty, 0);
    @(negedge clk); rst_n = 1;

    // R8: clean save via bus and via pin does nothing
    tag = "R8"; seq(16'h8FC0, 1'b0); idle();
    step(1, 1, 1, 0, 1, 0, 0, 1); idle();
    // R7: write marks dirty
    tag = "R7"; wr(17'h00123); idle();
    // R2: save then restore
    tag = "R2"; seq(16'h8FC0, 1'b0); drain();
    seq(16'h4C63, 1'b0); drain();
    // R3: bit 16 set
    tag = "R3"; wr(17'h1FFFF); seq(16'h8FC0, 1'b1); drain();
    // R4: write breaks, wrong read breaks, idle and oe-high cycles do not
    tag = "R4"; wr(17'h5);
    rd(seqa(0)); rd(seqa(1)); wr(17'h7); rd(seqa(2)); rd(seqa(3)); rd(seqa(4)); rd(16'h8FC0);
    rd(seqa(0)); rd(seqa(2)); rd(seqa(2)); rd(seqa(3)); rd(seqa(4)); rd(16'h8FC0);
    rd(seqa(0)); idle(); rd(seqa(1)); step(0, 1, 1, 17'h1234, 0, 0, 0, 1);
    rd(seqa(2)); rd(seqa(3)); idle(); rd(seqa(4)); rd(16'h8FC0); drain();
    // R5: controller stalls
    tag = "R5"; wr(17'h9);
    for (int i = 0; i < 5; i++) rd(seqa(i));
    rd(16'h8FC0, 1'b0); idle(1'b0); idle(1'b0); idle(1'b0); idle(1'b1); drain();
    // R6: bus traffic and requests during busy are dropped
    tag = "R6"; seq(16'h4C63, 1'b0); idle(1'b0);
    wr(17'h3); rd(seqa(0)); step(1, 1, 1, 0, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) rd(seqa(i));
    drain(); rd(16'h8FC0); idle();
    // R9: priority
    tag = "R9"; wr(17'h11); step(1, 1, 1, 0, 0, 1, 1, 1); drain();
    step(1, 1, 1, 0, 1, 0, 1, 1); drain();
    wr(17'h12); for (int i = 0; i < 5; i++) rd(seqa(i));
    step(0, 1, 0, {1'b0, 16'h8FC0}, 0, 0, 1, 1); drain();
    // R10: write with save pin in the same cycle while clean
    tag = "R10"; step(0, 0, 1, 17'h44, 1, 0, 0, 1); drain();
    step(0, 0, 1, 17'h45, 0, 1, 0, 1); drain();

    // random traffic
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 99);
      logic r = ($urandom_range(0, 3) != 0);
      if (k < 30) rd({1'($urandom), seqa(m_idx < 5 ? m_idx : 4)}, r);
      else if (k < 40) rd({1'($urandom), ($urandom_range(0, 1) ? 16'h8FC0 : 16'h4C63)}, r);
      else if (k < 55) rd(17'($urandom), r);
      else if (k < 65) wr(17'($urandom));
      else if (k < 68) step(1'($urandom), 1'($urandom), 1'($urandom), 17'($urandom),
                            1'b1, 1'b0, 1'b0, r);
      else if (k < 70) step(1'($urandom), 1'($urandom), 1'($urandom), 17'($urandom),
                            1'b0, 1'($urandom), 1'($urandom), r);
      else idle(r);
    end
    drain();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule